// File: doc/BRIEF.md
# Interleaved I/Q LVDS Transmit Serializer

This block sends complex baseband samples over a narrow source-synchronous bus. The bus has `LANES` data lines, a framing line and a forwarded clock. Each I or Q component is `2*LANES` bits wide, so it leaves the block as two `LANES`-bit halves, upper half first. One word period is eight bit slots. Two slots fit in each period of the forwarded bus clock, one per edge, so a word period lasts four bus-clock periods.

The block runs from a fast bit clock `clk` that carries one slot per cycle. A slot counter makes the word boundary internally, and the boundary doubles as the input handshake point. In MIMO mode a word carries a time-aligned pair of channels. In SISO mode the one channel-0 sample is sent in both halves of the word, so a receiver that copies channel 0 to both radios still sees matching data. When no new sample is offered at a boundary, the last one is sent again and the framing pattern keeps running. This lets a downstream deserializer find word alignment by bit-slipping until the framing pattern it captures is correct.

Top module: `lvds_iq_serializer`

## Requirements
- R1: From reset until the first slot of the first word, `lane_out`, `frame_out` and `fwd_clk_out` are all 0.
- R2: `in_ready` is high only in the last slot of each word, which is one cycle in eight, and it is low while `rst` is high. A sample is taken at the rising `clk` edge where `in_valid` and `in_ready` are both 1.
- R3: Slot 0 is driven in the cycle that follows the accepting edge. In slots 0 to 7 the lanes carry, in order: I0 upper, Q0 upper, I0 lower, Q0 lower, I1 upper, Q1 upper, I1 lower, Q1 lower. Upper is bits [2W-1:W] and lower is bits [W-1:0].
- R4: With `FRAME_INV`=0, `frame_out` is 1 in slots 0 to 3 and 0 in slots 4 to 7. The eight framing bits of a word, read oldest first into the MSB, form 8'hF0.
- R5: With `FRAME_INV`=1, the framing line is the complement once words are running, so the word reads 8'h0F.
- R6: Every component is XORed with `{LANE_INV_MASK, LANE_INV_MASK}` before it is split. Lane k is inverted when bit k of the mask is 1.
- R7: Once words are running, `fwd_clk_out` is 1 in even slots and 0 in odd slots. It toggles every cycle and has four periods per word.
- R8: When `mimo` is 1 at the accepting edge, channel 0 slots carry `in_i0`/`in_q0` and channel 1 slots carry `in_i1`/`in_q1`. Both pairs are taken at the same edge.
- R9: When `mimo` is 0 at the accepting edge, the channel 1 slots repeat `in_i0`/`in_q0`, and `in_i1`/`in_q1` have no effect.
- R10: When `in_valid` is 0 at a boundary, the next word repeats the previously taken sample and the framing pattern continues unchanged.
- R11: A receiver that starts sampling at any slot offset and slips one slot after each wrong framing word finds 8'hF0 within 7 slips, and it then recovers the sent samples.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bit clock, one slot per cycle |
| rst | input | 1 | Synchronous active-high reset |
| mimo | input | 1 | 1: two channels per word; 0: one channel sent twice |
| in_valid | input | 1 | Sample offered |
| in_ready | output | 1 | Word boundary; sample taken when valid |
| in_i0 | input | 2*LANES | Channel 0 in-phase |
| in_q0 | input | 2*LANES | Channel 0 quadrature |
| in_i1 | input | 2*LANES | Channel 1 in-phase |
| in_q1 | input | 2*LANES | Channel 1 quadrature |
| lane_out | output | LANES | Serial data lanes |
| frame_out | output | 1 | Framing line |
| fwd_clk_out | output | 1 | Forwarded DDR bus clock |

## Verification
A sample taken at the rising edge where `in_ready` is high shows up on the lanes in the next cycle as slot 0. Slot n then appears n cycles after that. `in_ready` comes back in slot 7, and `in_ready` and the reset state are combinational from flops, so they can be seen in the same cycle. The bench drives inputs on falling edges and reads outputs on the falling edge that follows each rising edge. Its receiver only ever consumes whole groups of eight falling edges once it is aligned. Because of this, every check lands on a known slot, and an input change made in slot 7 is checked in the word that follows.

// File: rtl/lvds_ser_pkg.sv
package lvds_ser_pkg;
  localparam int SLOT_W = 3;
  localparam int SLOTS  = 1 << SLOT_W;

  typedef logic [SLOT_W-1:0] slot_t;

  // Component index for a slot: bit1 = channel, bit0 = quadrature.
  function automatic logic [1:0] slot_comp(input slot_t s);
    return {s[2], s[0]};
  endfunction

  // Upper half occupies slots whose bit1 is clear.
  function automatic logic slot_is_upper(input slot_t s);
    return ~s[1];
  endfunction

  // Channel 0 half of the word marks the framing line.
  function automatic logic frame_level(input slot_t s, input logic inv);
    return (~s[2]) ^ inv;
  endfunction

  // Forwarded clock is high on even slots (one edge per slot).
  function automatic logic bus_clk_level(input slot_t s);
    return ~s[0];
  endfunction
endpackage

// File: rtl/ser_slot_counter.sv
module ser_slot_counter
  import lvds_ser_pkg::*;
(
  input  logic  clk,
  input  logic  rst,
  output slot_t slot,
  output logic  run,
  output logic  boundary
);
  localparam slot_t LAST = slot_t'(SLOTS - 1);

  // Reset parks the counter on the last slot so the first boundary
  // follows the release of reset immediately.
  always_ff @(posedge clk) begin
    if (rst) begin
      slot <= LAST;
      run  <= 1'b0;
    end else begin
      slot <= (slot == LAST) ? '0 : slot + slot_t'(1);
      if (slot == LAST) run <= 1'b1;
    end
  end

  assign boundary = (slot == LAST) && !rst;
endmodule

// File: rtl/ser_word_capture.sv
module ser_word_capture #(
  parameter int LANES = 6,
  localparam int CW = 2 * LANES
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                load,
  input  logic                mimo,
  input  logic [CW-1:0]       i0,
  input  logic [CW-1:0]       q0,
  input  logic [CW-1:0]       i1,
  input  logic [CW-1:0]       q1,
  output logic [3:0][CW-1:0]  word_q
);
  logic [CW-1:0] ch1_i, ch1_q;

  // Single-channel mode sends channel 0 in both halves of the word.
  assign ch1_i = mimo ? i1 : i0;
  assign ch1_q = mimo ? q1 : q0;

  always_ff @(posedge clk) begin
    if (rst) begin
      word_q <= '0;
    end else if (load) begin
      word_q[0] <= i0;
      word_q[1] <= q0;
      word_q[2] <= ch1_i;
      word_q[3] <= ch1_q;
    end
  end
endmodule

// File: rtl/ser_slot_mux.sv
module ser_slot_mux
  import lvds_ser_pkg::*;
#(
  parameter int                LANES         = 6,
  parameter logic [LANES-1:0]  LANE_INV_MASK = '0,
  parameter bit                FRAME_INV     = 1'b0,
  localparam int CW = 2 * LANES
) (
  input  logic [3:0][CW-1:0] word_q,
  input  slot_t              slot,
  input  logic               run,
  output logic [LANES-1:0]   lane_out,
  output logic               frame_out,
  output logic               fwd_clk_out
);
  logic [CW-1:0] comp;
  logic [CW-1:0] comp_inv;

  assign comp = word_q[slot_comp(slot)];

  generate
    if (LANE_INV_MASK == '0) begin : g_plain
      assign comp_inv = comp;
    end else begin : g_inv
      assign comp_inv = comp ^ {LANE_INV_MASK, LANE_INV_MASK};
    end
  endgenerate

  always_comb begin
    lane_out    = '0;
    frame_out   = 1'b0;
    fwd_clk_out = 1'b0;
    if (run) begin
      lane_out    = slot_is_upper(slot) ? comp_inv[CW-1:LANES] : comp_inv[LANES-1:0];
      frame_out   = frame_level(slot, FRAME_INV);
      fwd_clk_out = bus_clk_level(slot);
    end
  end
endmodule

// File: rtl/lvds_iq_serializer.sv
module lvds_iq_serializer
  import lvds_ser_pkg::*;
#(
  parameter int                LANES         = 6,
  parameter logic [LANES-1:0]  LANE_INV_MASK = '0,
  parameter bit                FRAME_INV     = 1'b0,
  localparam int CW = 2 * LANES
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             mimo,
  input  logic             in_valid,
  output logic             in_ready,
  input  logic [CW-1:0]    in_i0,
  input  logic [CW-1:0]    in_q0,
  input  logic [CW-1:0]    in_i1,
  input  logic [CW-1:0]    in_q1,
  output logic [LANES-1:0] lane_out,
  output logic             frame_out,
  output logic             fwd_clk_out
);
  slot_t              slot;
  logic               slot_run;
  logic               slot_bound;
  logic               take;
  logic [3:0][CW-1:0] word_q;

  ser_slot_counter u_cnt (
    .clk      (clk),
    .rst      (rst),
    .slot     (slot),
    .run      (slot_run),
    .boundary (slot_bound)
  );

  assign in_ready = slot_bound;
  assign take     = slot_bound && in_valid;

  ser_word_capture #(.LANES(LANES)) u_cap (
    .clk    (clk),
    .rst    (rst),
    .load   (take),
    .mimo   (mimo),
    .i0     (in_i0),
    .q0     (in_q0),
    .i1     (in_i1),
    .q1     (in_q1),
    .word_q (word_q)
  );

  ser_slot_mux #(
    .LANES         (LANES),
    .LANE_INV_MASK (LANE_INV_MASK),
    .FRAME_INV     (FRAME_INV)
  ) u_mux (
    .word_q      (word_q),
    .slot        (slot),
    .run         (slot_run),
    .lane_out    (lane_out),
    .frame_out   (frame_out),
    .fwd_clk_out (fwd_clk_out)
  );
endmodule

// File: rtl/lvds_iq_serializer_chk.sv
module lvds_iq_serializer_chk #(
  parameter int                LANES         = 6,
  parameter logic [LANES-1:0]  LANE_INV_MASK = '0,
  parameter bit                FRAME_INV     = 1'b0,
  localparam int CW = 2 * LANES
) (
  input logic               clk,
  input logic               rst,
  input logic               mimo,
  input logic               in_valid,
  input logic               in_ready,
  input logic [CW-1:0]      in_i0,
  input logic [CW-1:0]      in_q0,
  input logic [LANES-1:0]   lane_out,
  input logic               frame_out,
  input logic               fwd_clk_out,
  input logic               slot_run,
  input logic [3:0][CW-1:0] word_q
);
  logic [LANES-1:0] i0_hi;
  assign i0_hi = in_i0[CW-1:LANES];

  // R1
  idle_low_chk: assert property (@(posedge clk) disable iff (rst)
    !slot_run |-> (lane_out == '0 && !frame_out && !fwd_clk_out));

  // R2
  ready_single_chk: assert property (@(posedge clk) disable iff (rst)
    in_ready |=> !in_ready);

  // R3
  first_slot_chk: assert property (@(posedge clk) disable iff (rst)
    (in_ready && in_valid) |=> lane_out == ($past(i0_hi) ^ LANE_INV_MASK));

  // R4
  frame_start_chk: assert property (@(posedge clk) disable iff (rst)
    in_ready |=> frame_out == !FRAME_INV);

  // R5
  frame_tail_chk: assert property (@(posedge clk) disable iff (rst)
    (in_ready && slot_run) |-> frame_out == FRAME_INV);

  // R7
  fwd_toggle_chk: assert property (@(posedge clk) disable iff (rst)
    slot_run |-> fwd_clk_out != $past(fwd_clk_out));

  // R9
  siso_dup_chk: assert property (@(posedge clk) disable iff (rst)
    (in_ready && in_valid && !mimo) |=>
      (word_q[2] == $past(in_i0) && word_q[3] == $past(in_q0)));

  // R10
  hold_word_chk: assert property (@(posedge clk) disable iff (rst)
    (in_ready && !in_valid) |=> $stable(word_q));
endmodule

bind lvds_iq_serializer lvds_iq_serializer_chk #(
  .LANES         (LANES),
  .LANE_INV_MASK (LANE_INV_MASK),
  .FRAME_INV     (FRAME_INV)
) u_chk (
  .clk         (clk),
  .rst         (rst),
  .mimo        (mimo),
  .in_valid    (in_valid),
  .in_ready    (in_ready),
  .in_i0       (in_i0),
  .in_q0       (in_q0),
  .lane_out    (lane_out),
  .frame_out   (frame_out),
  .fwd_clk_out (fwd_clk_out),
  .slot_run    (slot_run),
  .word_q      (word_q)
);

// File: tb/sim_lvds_iq_serializer.sv
module sim_lvds_iq_serializer;
  localparam int W  = 6;
  localparam int CW = 2 * W;
  localparam logic [W-1:0] MASK = 6'b100101;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic mimo = 1'b1;
  logic in_valid = 1'b0;
  logic [CW-1:0] i0 = '0, q0 = '0, i1 = '0, q1 = '0;
  logic rdy0, rdy1, frm0, frm1, fwd0, fwd1;
  logic [W-1:0] ln0, ln1;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  lvds_iq_serializer #(.LANES(W), .LANE_INV_MASK(MASK), .FRAME_INV(1'b0)) u0 (
    .clk(clk), .rst(rst), .mimo(mimo), .in_valid(in_valid), .in_ready(rdy0),
    .in_i0(i0), .in_q0(q0), .in_i1(i1), .in_q1(q1),
    .lane_out(ln0), .frame_out(frm0), .fwd_clk_out(fwd0));

  lvds_iq_serializer #(.LANES(W), .LANE_INV_MASK(MASK), .FRAME_INV(1'b1)) u1 (
    .clk(clk), .rst(rst), .mimo(mimo), .in_valid(in_valid), .in_ready(rdy1),
    .in_i0(i0), .in_q0(q0), .in_i1(i1), .in_q1(q1),
    .lane_out(ln1), .frame_out(frm1), .fwd_clk_out(fwd1));

  // Receiver capture of one word, oldest slot first.
  logic [W-1:0] rx_lane [8];
  logic [7:0]   rx_frm, rx_frm1;

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [W-1:0] exp_slot(input int s, input logic [CW-1:0] a0, b0, a1, b1);
    logic [CW-1:0] c;
    case (s)
      0, 2:    c = a0;
      1, 3:    c = b0;
      4, 6:    c = a1;
      default: c = b1;
    endcase
    c = c ^ {MASK, MASK};
    return (s == 0 || s == 1 || s == 4 || s == 5) ? c[CW-1:W] : c[W-1:0];
  endfunction

  task automatic skip(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic grab();
    for (int k = 0; k < 8; k++) begin
      @(negedge clk);
      rx_lane[k] = ln0;
      rx_frm  = {rx_frm[6:0], frm0};
      rx_frm1 = {rx_frm1[6:0], frm1};
    end
  endtask

  task automatic check_word(input string req, input logic [CW-1:0] a0, b0, a1, b1);
    chk(req, {20'd0, {rx_lane[0], rx_lane[2]} ^ {MASK, MASK}}, {20'd0, a0});
    chk(req, {20'd0, {rx_lane[1], rx_lane[3]} ^ {MASK, MASK}}, {20'd0, b0});
    chk(req, {20'd0, {rx_lane[4], rx_lane[6]} ^ {MASK, MASK}}, {20'd0, a1});
    chk(req, {20'd0, {rx_lane[5], rx_lane[7]} ^ {MASK, MASK}}, {20'd0, b1});
  endtask

  task automatic t_reset();
    rst = 1'b1; in_valid = 1'b0;
    skip(4);
    chk("R2 ready low in reset", {31'd0, rdy0}, 32'd0);
    rst = 1'b0;
    #1;
    chk("R1 lanes idle", {26'd0, ln0}, 32'd0);
    chk("R1 frame idle", {31'd0, frm0}, 32'd0);
    chk("R1 inverted frame idle", {31'd0, frm1}, 32'd0);
    chk("R1 fwd clk idle", {31'd0, fwd0}, 32'd0);
    chk("R2 ready at first boundary", {31'd0, rdy0}, 32'd1);
  endtask

  // Slot-by-slot check of the first word (R3, R4, R6, R7, R2).
  task automatic t_slot_order();
    mimo = 1'b1; in_valid = 1'b1;
    i0 = 12'hA53; q0 = 12'h3C7; i1 = 12'h9E1; q1 = 12'h16B;
    for (int s = 0; s < 8; s++) begin
      @(negedge clk);
      chk("R3 R6 slot lane", {26'd0, ln0}, {26'd0, exp_slot(s, i0, q0, i1, q1)});
      chk("R4 frame level", {31'd0, frm0}, {31'd0, (s < 4)});
      chk("R5 inverted frame level", {31'd0, frm1}, {31'd0, (s >= 4)});
      chk("R7 fwd clk level", {31'd0, fwd0}, {31'd0, (s % 2 == 0)});
      chk("R2 ready slot", {31'd0, rdy0}, {31'd0, (s == 7)});
    end
  endtask

  // Receiver starts off-phase and bit-slips to the framing pattern (R11).
  task automatic t_align();
    int slips = 0;
    bit ok = 1'b0;
    skip(3);
    for (int a = 0; a < 12 && !ok; a++) begin
      grab();
      if (rx_frm == 8'hF0) ok = 1'b1;
      else begin
        skip(1);
        slips++;
      end
    end
    chk("R11 aligned", {31'd0, ok}, 32'd1);
    chk("R11 slips within 7", {31'd0, (slips <= 7)}, 32'd1);
    chk("R5 inverted frame word", {24'd0, rx_frm1}, 32'h0F);
    grab();
    chk("R4 frame word", {24'd0, rx_frm}, 32'hF0);
    check_word("R8 R11 mimo recover", 12'hA53, 12'h3C7, 12'h9E1, 12'h16B);
  endtask

  task automatic t_mimo_new();
    i0 = 12'h0F1; q0 = 12'hE2D; i1 = 12'h555; q1 = 12'hAAA;
    skip(8);
    grab();
    check_word("R8 mimo second sample", 12'h0F1, 12'hE2D, 12'h555, 12'hAAA);
  endtask

  task automatic t_siso();
    mimo = 1'b0;
    i0 = 12'h7B4; q0 = 12'h2C9; i1 = 12'hFFF; q1 = 12'h000;
    skip(8);
    grab();
    check_word("R9 siso duplicate", 12'h7B4, 12'h2C9, 12'h7B4, 12'h2C9);
  endtask

  task automatic t_hold();
    in_valid = 1'b0;
    i0 = 12'h111; q0 = 12'h222; i1 = 12'h333; q1 = 12'h444;
    skip(8);
    grab();
    check_word("R10 repeat last sample", 12'h7B4, 12'h2C9, 12'h7B4, 12'h2C9);
    chk("R10 frame continues", {24'd0, rx_frm}, 32'hF0);
    in_valid = 1'b1; mimo = 1'b1;
    skip(8);
    grab();
    check_word("R8 resume after hold", 12'h111, 12'h222, 12'h333, 12'h444);
  endtask

  initial begin
    t_reset();
    t_slot_order();
    t_align();
    t_mimo_new();
    t_siso();
    t_hold();
    if (!done) begin
      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      checks++;
      failures++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule